// File: doc/BRIEF.md
# Scatter-Gather Segment List Walker

This block turns a hash or DMA request into an ordered stream of memory segments for a downstream data fetcher. In direct mode the request is one contiguous region: the walker emits a single segment built from the base address and a 28-bit length, and it reads nothing from memory. In scatter-gather mode the base address points at a table of 8-byte descriptors. The walker reads the descriptors one at a time through a single-word read master port and emits one segment per descriptor.

Each descriptor holds two little-endian 32-bit words. The length word is at byte offset 0 and the address word is at offset 4. The walk ends at the descriptor whose length word carries the end marker, or at a fixed cap on the number of descriptors. When the walk finishes, the walker pulses `done_o` and shows how many segments were accepted. An error flag reports a table that reached the cap without an end marker. Segments leave over a valid/ready handshake, and the next descriptor is fetched only after the current segment has been taken.

Top module: `sg_walker`

## Requirements
- R1: With `sg_mode_i` low, a start emits exactly one segment with address `base_addr_i`, length `direct_len_i` and `seg_last_o` high, and `rd_req_o` stays low for the whole walk.
- R2: In scatter-gather mode, descriptor i is read as two word reads in this order: the length word at `base_addr_i + 8*i`, then the address word at `base_addr_i + 8*i + 4`.
- R3: A segment's length is bits 27:0 of its length word. Bits 30:28 are dropped.
- R4: A segment's address is its address word with bit 31 forced to 0.
- R5: A length word with bit 31 set marks the final descriptor. That segment is emitted with `seg_last_o` high, and no further descriptor is read.
- R6: While a segment is offered (`seg_valid_o` high), no read request is made. The next descriptor is fetched only after the segment is accepted.
- R7: An offered segment keeps `seg_valid_o` high and its address, length and last flag unchanged until `seg_ready_i` accepts it.
- R8: At most MAX_DESC (256) descriptors are processed. If descriptor 255 has no end marker, it is still emitted with `seg_last_o` high, the walk ends, and `err_o` is set.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final segment is accepted. `seg_count_o` then equals the number of segments accepted. `err_o` and `seg_count_o` hold until the next accepted start, which clears them.
- R10: A segment of length zero is still emitted in its place in the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk. Accepted only when idle. |
| sg_mode_i | input | 1 | 1 = descriptor table, 0 = direct single segment |
| base_addr_i | input | 32 | Table base (scatter-gather) or segment address (direct) |
| direct_len_i | input | 28 | Segment length in direct mode |
| rd_req_o | output | 1 | Word read request, held until acknowledged |
| rd_addr_o | output | 32 | Byte address of the word read |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid in the same cycle |
| rd_data_i | input | 32 | Read data word |
| seg_valid_o | output | 1 | Segment offered |
| seg_ready_i | input | 1 | Downstream accepts the offered segment |
| seg_addr_o | output | 32 | Segment start address |
| seg_len_o | output | 28 | Segment length in bytes |
| seg_last_o | output | 1 | Segment is the final one of the walk |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| seg_count_o | output | 9 | Segments accepted in the current or last walk |
| err_o | output | 1 | Cap reached with no end marker |

## Verification
The assertions check the properties that hold on every cycle. No read is issued while a segment is offered or during a direct walk. An offered segment stays stable until it is accepted. The length-word read is followed by a read of the next word address. A last segment that is accepted is followed by a single-cycle done pulse. The bench's scenarios are needed for everything that depends on table contents. They show that each emitted field is masked correctly from its descriptor words and that walks end on the end marker. They also cover the error path at 256 entries, the zero-length entries, and the clearing of the error flag at the next start. Random read latency and random ready stalls are applied throughout.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int WORD_W      = 32;
  localparam int SEG_LEN_W   = 28;
  localparam int FINAL_BIT   = 31;
  localparam int DESC_BYTES  = 8;
  localparam int ADDR_OFS    = 4;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_EMIT, W_DONE} walk_st_e;
  typedef enum logic [1:0] {F_IDLE, F_LEN, F_ADDR} fetch_st_e;

  function automatic logic [SEG_LEN_W-1:0] seg_len_of(input logic [WORD_W-1:0] w);
    return w[SEG_LEN_W-1:0];
  endfunction

  function automatic logic is_final(input logic [WORD_W-1:0] w);
    return w[FINAL_BIT];
  endfunction

  function automatic logic [WORD_W-1:0] seg_addr_of(input logic [WORD_W-1:0] w);
    return {1'b0, w[WORD_W-2:0]};
  endfunction

  function automatic logic [WORD_W-1:0] desc_base(input logic [WORD_W-1:0] base,
                                                  input logic [WORD_W-1:0] idx);
    return base + idx * WORD_W'(DESC_BYTES);
  endfunction
endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] idx_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              desc_vld_o,
  output logic [WORD_W-1:0] len_word_o,
  output logic [WORD_W-1:0] addr_word_o
);
  fetch_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      rd_addr_o   <= '0;
      desc_vld_o  <= 1'b0;
      len_word_o  <= '0;
      addr_word_o <= '0;
    end else begin
      desc_vld_o <= 1'b0;
      case (st_q)
        F_IDLE: if (go_i) begin
          rd_addr_o <= desc_base(base_i, idx_i);
          st_q      <= F_LEN;
        end
        F_LEN: if (rd_ack_i) begin
          len_word_o <= rd_data_i;
          rd_addr_o  <= rd_addr_o + WORD_W'(ADDR_OFS);
          st_q       <= F_ADDR;
        end
        F_ADDR: if (rd_ack_i) begin
          addr_word_o <= rd_data_i;
          desc_vld_o  <= 1'b1;
          st_q        <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign rd_req_o = (st_q != F_IDLE);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_LEN && rd_ack_i) |=> (rd_req_o && rd_addr_o == $past(rd_addr_o) + 32'd4));
endmodule

// File: rtl/sgw_seg_reg.sv
module sgw_seg_reg
  import sgw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [WORD_W-1:0]    addr_i,
  input  logic [SEG_LEN_W-1:0] len_i,
  input  logic                 last_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [WORD_W-1:0]    addr_o,
  output logic [SEG_LEN_W-1:0] len_o,
  output logic                 last_o,
  output logic                 accept_o
);
  assign accept_o = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      len_o   <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      len_o   <= len_i;
      last_o  <= last_i;
    end else if (accept_o) begin
      valid_o <= 1'b0;
    end
  end

  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(len_o) && $stable(last_o)));
endmodule

// File: rtl/sg_walker.sv
module sg_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 256,
  localparam int IDX_W   = $clog2(MAX_DESC),
  localparam int CNT_W   = $clog2(MAX_DESC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 sg_mode_i,
  input  logic [WORD_W-1:0]    base_addr_i,
  input  logic [SEG_LEN_W-1:0] direct_len_i,
  output logic                 rd_req_o,
  output logic [WORD_W-1:0]    rd_addr_o,
  input  logic                 rd_ack_i,
  input  logic [WORD_W-1:0]    rd_data_i,
  output logic                 seg_valid_o,
  input  logic                 seg_ready_i,
  output logic [WORD_W-1:0]    seg_addr_o,
  output logic [SEG_LEN_W-1:0] seg_len_o,
  output logic                 seg_last_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [CNT_W-1:0]     seg_count_o,
  output logic                 err_o
);
  walk_st_e             st_q;
  logic                 sg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [WORD_W-1:0]    base_q;
  logic                 fetch_go_q;
  logic                 desc_vld;
  logic [WORD_W-1:0]    len_word, addr_word;
  logic                 seg_load, seg_accept;
  logic [WORD_W-1:0]    nxt_addr;
  logic [SEG_LEN_W-1:0] nxt_len;
  logic                 nxt_last;
  logic                 start_take;
  logic                 at_cap;

  assign start_take = (st_q == W_IDLE) && start_i;
  assign at_cap     = (idx_q == IDX_W'(MAX_DESC - 1));

  sgw_desc_fetch u_fetch (
    .clk, .rst_n,
    .go_i       (fetch_go_q),
    .base_i     (base_q),
    .idx_i      (WORD_W'(idx_q)),
    .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .desc_vld_o (desc_vld),
    .len_word_o (len_word),
    .addr_word_o(addr_word)
  );

  always_comb begin
    if (desc_vld) begin
      nxt_addr = seg_addr_of(addr_word);
      nxt_len  = seg_len_of(len_word);
      nxt_last = is_final(len_word) || at_cap;
    end else begin
      nxt_addr = base_addr_i;
      nxt_len  = direct_len_i;
      nxt_last = 1'b1;
    end
    seg_load = desc_vld || (start_take && !sg_mode_i);
  end

  sgw_seg_reg u_seg (
    .clk, .rst_n,
    .load_i  (seg_load),
    .addr_i  (nxt_addr),
    .len_i   (nxt_len),
    .last_i  (nxt_last),
    .ready_i (seg_ready_i),
    .valid_o (seg_valid_o),
    .addr_o  (seg_addr_o),
    .len_o   (seg_len_o),
    .last_o  (seg_last_o),
    .accept_o(seg_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= W_IDLE;
      sg_q        <= 1'b0;
      idx_q       <= '0;
      base_q      <= '0;
      fetch_go_q  <= 1'b0;
      seg_count_o <= '0;
      err_o       <= 1'b0;
    end else begin
      fetch_go_q <= 1'b0;
      case (st_q)
        W_IDLE: if (start_i) begin
          sg_q        <= sg_mode_i;
          base_q      <= base_addr_i;
          idx_q       <= '0;
          seg_count_o <= '0;
          err_o       <= 1'b0;
          fetch_go_q  <= sg_mode_i;
          st_q        <= sg_mode_i ? W_FETCH : W_EMIT;
        end
        W_FETCH: if (desc_vld) begin
          err_o <= at_cap && !is_final(len_word);
          st_q  <= W_EMIT;
        end
        W_EMIT: if (seg_accept) begin
          seg_count_o <= seg_count_o + 1'b1;
          if (seg_last_o) begin
            st_q <= W_DONE;
          end else begin
            idx_q      <= idx_q + 1'b1;
            fetch_go_q <= 1'b1;
            st_q       <= W_FETCH;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == W_FETCH) || (st_q == W_EMIT);
  assign done_o = (st_q == W_DONE);

  // R6
  no_fetch_while_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid_o |-> !rd_req_o);
  // R1
  direct_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !sg_q) |-> !rd_req_o);
  // R5
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid_o && seg_ready_i && seg_last_o) |=> done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(err_o) && $stable(seg_count_o));
  // R8
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_count_o <= CNT_W'(MAX_DESC));
endmodule

// File: tb/tb_sg_walker.sv
`timescale 1ns/1ps
module tb_sg_walker;
  localparam int MAXD = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, sg_mode_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [27:0] direct_len_i = '0;
  logic        rd_req_o, rd_ack_i, seg_valid_o, seg_ready_i, seg_last_o;
  logic [31:0] rd_addr_o, rd_data_i, seg_addr_o;
  logic [27:0] seg_len_o;
  logic        busy_o, done_o, err_o;
  logic [8:0]  seg_count_o;

  always #2.5 clk = ~clk;

  sg_walker dut (.*);

  int n_chk = 0, n_fail = 0;
  bit [31:0] mem [int unsigned];
  int rd_cnt = 0;
  bit [31:0] cur_base = 0;
  bit [31:0] tl[$], ta[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model with random latency; checks read order (R2)
  always @(posedge clk) begin
    if (!rst_n) rd_ack_i <= 1'b0;
    else if (rd_ack_i) rd_ack_i <= 1'b0;
    else if (rd_req_o && ($urandom % 4 != 0)) begin
      automatic bit [31:0] ea = cur_base + 32'(8 * (rd_cnt / 2) + 4 * (rd_cnt % 2));
      chk(rd_addr_o == ea, "R2", "read address", rd_addr_o, ea);
      rd_ack_i  <= 1'b1;
      rd_data_i <= mem.exists(rd_addr_o >> 2) ? mem[rd_addr_o >> 2] : 32'h0;
      rd_cnt++;
    end
  end

  task automatic put_table(input bit [31:0] base);
    for (int i = 0; i < tl.size(); i++) begin
      mem[(base >> 2) + 32'(2 * i)]     = tl[i];
      mem[(base >> 2) + 32'(2 * i + 1)] = ta[i];
    end
  endtask

  task automatic run_walk(input bit sg, input bit [31:0] base, input bit [27:0] dlen,
                          input string tag);
    bit [31:0] ea[$]; bit [27:0] el[$]; bit elast[$];
    bit exp_err = 0; int k = 0; int cyc = 0; bit fin = 0;
    if (sg) begin
      for (int i = 0; i < tl.size() && i < MAXD; i++) begin
        ea.push_back(ta[i] & 32'h7FFF_FFFF);
        el.push_back(tl[i][27:0]);
        elast.push_back(tl[i][31] || i == MAXD - 1);
        if (i == MAXD - 1 && !tl[i][31]) exp_err = 1;
        if (tl[i][31] || i == MAXD - 1) break;
      end
    end else begin
      ea.push_back(base); el.push_back(dlen); elast.push_back(1'b1);
    end
    @(negedge clk);
    cur_base = base; rd_cnt = 0;
    sg_mode_i = sg; base_addr_i = base; direct_len_i = dlen; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !err_o && seg_count_o == 0, "R9", {tag, " start clears"},
        {busy_o, err_o, 7'(seg_count_o)}, 64'h100);
    while (!fin) begin
      seg_ready_i = ($urandom % 10) < 7;
      #1;
      if (seg_valid_o && seg_ready_i) begin
        if (k < ea.size()) begin
          chk(seg_addr_o == ea[k], "R4", {tag, " seg addr"}, seg_addr_o, ea[k]);
          chk(seg_len_o == el[k], el[k] == 0 ? "R10" : "R3", {tag, " seg len"}, seg_len_o, el[k]);
          chk(seg_last_o == elast[k], sg ? "R5" : "R1", {tag, " seg last"}, seg_last_o, elast[k]);
        end else chk(0, "R5", {tag, " extra segment"}, k, ea.size());
        k++;
      end
      if (done_o) fin = 1;
      cyc++;
      if (cyc > 20000) begin
        chk(0, "R9", {tag, " walk timeout"}, cyc, 0);
        fin = 1;
      end
      if (!fin) @(negedge clk);
    end
    seg_ready_i = 1'b0;
    chk(k == ea.size(), "R5", {tag, " segments seen"}, k, ea.size());
    chk(seg_count_o == 9'(ea.size()), "R9", {tag, " count"}, seg_count_o, ea.size());
    chk(err_o == exp_err, "R8", {tag, " err"}, err_o, exp_err);
    chk(rd_cnt == (sg ? 2 * ea.size() : 0), sg ? "R6" : "R1", {tag, " read count"},
        rd_cnt, sg ? 2 * ea.size() : 0);
    @(negedge clk);
    chk(!done_o, "R9", {tag, " done one cycle"}, done_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    seg_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!seg_valid_o && !done_o && !busy_o && !err_o && !rd_req_o && seg_count_o == 0,
        "R9", "reset state", {seg_valid_o, done_o, busy_o, err_o, rd_req_o}, 0);
    rst_n = 1'b1;

    // R1 direct mode
    run_walk(0, 32'h8000_1230, 28'h0AB_CDEF, "direct");
    run_walk(0, 32'h0000_0040, 28'h0, "direct-zero");

    // R3 R4 R10: masking and zero length, terminator at index 2, junk after
    tl = {32'h7000_0010, 32'h0000_0000, 32'h9FFF_FFFF, 32'h0000_0005};
    ta = {32'hFFFF_FFF0, 32'h8000_0100, 32'h0000_0200, 32'h1234_5678};
    put_table(32'h0000_2000);
    run_walk(1, 32'h0000_2000, 0, "masked");

    // R5 single terminated descriptor
    tl = {32'h8000_0040}; ta = {32'h0000_4000};
    put_table(32'h0000_3000);
    run_walk(1, 32'h0000_3000, 0, "single");

    // R8 cap reached without terminator
    tl = {}; ta = {};
    for (int i = 0; i < MAXD + 2; i++) begin
      tl.push_back({1'b0, 3'($urandom), 28'($urandom)});
      ta.push_back($urandom);
    end
    put_table(32'h0001_0000);
    run_walk(1, 32'h0001_0000, 0, "cap");
    repeat (4) @(negedge clk);
    chk(err_o && seg_count_o == 9'd256, "R9", "err holds", {err_o, seg_count_o}, {1'b1, 9'd256});

    // R8 terminator exactly on entry 255: no error
    tl[MAXD - 1][31] = 1'b1;
    put_table(32'h0002_0000);
    run_walk(1, 32'h0002_0000, 0, "cap-term");

    // random lists
    for (int r = 0; r < 20; r++) begin
      int n = 1 + ($urandom % 8);
      bit [31:0] b = 32'h0004_0000 + 32'(r) * 32'h100;
      tl = {}; ta = {};
      for (int i = 0; i < n; i++) begin
        tl.push_back({(i == n - 1), 3'($urandom), ($urandom % 5 == 0) ? 28'h0 : 28'($urandom)});
        ta.push_back($urandom);
      end
      put_table(b);
      run_walk(1, b, 0, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule